// File: doc/BRIEF.md
# Configurable-Format Serial Character Transmitter

This block turns one byte at a time into an asynchronous serial frame on a single output line. The host sets the frame shape through an 8-bit line format register, which it can write and read back at any time. The format covers the word length (5 to 8 bits), an optional odd or even parity bit, and a stop period of one, one and a half, or two bit times. The number of stop bits depends on both the stop-select flag and the word length.

Bit timing comes from a tick input that pulses at sixteen times the bit rate, so one bit lasts sixteen ticks and a one-and-a-half stop period lasts twenty-four. The block has a one-entry holding stage in front of the serializer. The host can therefore queue the next byte while the current frame is still on the line, and back-to-back frames leave no idle time between them. The serializer takes a copy of the line format at the moment it takes a byte. A format write only changes the shape of the next character, never the one on the line.

Top module: `uart_frame_tx`

## Requirements
- R1: Format bits [1:0] choose the word length: 00 gives 5 data bits, 01 gives 6, 10 gives 7 and 11 gives 8. A frame opens with a low start bit and then sends the data bits least significant first. Data bits above the chosen length are never sent.
- R2: When format bit [2] is 0, the stop period is one high bit of 16 ticks.
- R3: When format bit [2] is 1, a 5-bit word gets a stop period of 24 ticks (one and a half bits), and a 6-, 7- or 8-bit word gets 32 ticks (two bits).
- R4: Format bit [3] set adds a parity bit after the data bits. Format bit [4] picks the sense: 1 gives even parity (the parity bit is the XOR of the data bits sent), 0 gives odd parity (its inverse).
- R5: `cfg_rdata` returns all 8 bits last written through `cfg_we`/`cfg_wdata`, including bits [7:5], which have no effect on the frame. It resets to 0.
- R6: The start, data and parity bits each hold the line for exactly 16 tick pulses. The line does not change while a frame is on it unless a tick pulse occurs.
- R7: The format is copied when a character enters the serializer. A format write in that same clock cycle, or any later write, does not affect that character.
- R8: `tx_load` with `busy` low stores `tx_data` in the holding stage. `busy` is high while the holding stage is full. A `tx_load` while `busy` is high is ignored and produces no frame.
- R9: After reset, `txd` is 1, `busy` is 0 and `empty` is 1. `empty` is high only when the holding stage is empty and the last stop period has finished, and the line is then high.
- R10: A byte that is waiting when a stop period ends starts its start bit on the same clock edge, with no idle tick in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| tx_data | input | 8 | Byte to send |
| tx_load | input | 1 | Strobe that offers `tx_data` to the holding stage |
| cfg_we | input | 1 | Write strobe for the line format register |
| cfg_wdata | input | 8 | New line format value |
| cfg_rdata | output | 8 | Current line format value |
| txd | output | 1 | Serial line, idles high |
| busy | output | 1 | Holding stage full; further loads are ignored |
| empty | output | 1 | Nothing held and no frame on the line |

## Verification
Two events can fall in the same clock cycle. The first is a format register write and the transfer of a byte into the serializer. The bench loads a byte into an idle block and then writes a new format exactly in the transfer cycle. It expects the frame on the line to use the old format and the next byte to use the new one. The second is the end of one frame's stop period and the start of a queued frame. The bench keeps a byte waiting in the holding stage and checks two things: the stop period before it has its full length, and the next start bit follows with no idle tick.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int WORD_MAX = 8;
    localparam int IDX_W    = $clog2(WORD_MAX);

    // Line format register layout
    typedef struct packed {
        logic [2:0] spare;
        logic       par_even;
        logic       par_on;
        logic       stop_long;
        logic [1:0] wlen;
    } line_fmt_t;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PARITY,
        TX_STOP
    } tx_phase_e;

    typedef enum logic [1:0] {
        STOP_1,
        STOP_1P5,
        STOP_2
    } stop_len_e;

    // Everything the serializer needs for one character
    typedef struct packed {
        logic [WORD_MAX-1:0] bits;
        logic [IDX_W-1:0]    last_idx;
        logic                par_on;
        logic                par_val;
        stop_len_e           stop_len;
    } frame_plan_t;

    function automatic stop_len_e stop_len_of(line_fmt_t f);
        stop_len_e s;
        if (!f.stop_long)
            s = STOP_1;
        else if (f.wlen == 2'b00)
            s = STOP_1P5;
        else
            s = STOP_2;
        return s;
    endfunction

    function automatic logic [WORD_MAX-1:0] mask_word(logic [WORD_MAX-1:0] d,
                                                      logic [1:0] wlen);
        logic [WORD_MAX-1:0] m;
        case (wlen)
            2'b00:   m = WORD_MAX'(8'h1F);
            2'b01:   m = WORD_MAX'(8'h3F);
            2'b10:   m = WORD_MAX'(8'h7F);
            default: m = WORD_MAX'(8'hFF);
        endcase
        return d & m;
    endfunction

    function automatic logic parity_of(logic [WORD_MAX-1:0] d, logic even);
        return even ? (^d) : ~(^d);
    endfunction

    function automatic frame_plan_t plan_frame(logic [WORD_MAX-1:0] d, line_fmt_t f);
        frame_plan_t p;
        p.bits     = mask_word(d, f.wlen);
        p.last_idx = IDX_W'(f.wlen) + IDX_W'(4);
        p.par_on   = f.par_on;
        p.par_val  = parity_of(p.bits, f.par_even);
        p.stop_len = stop_len_of(f);
        return p;
    endfunction

endpackage

// File: rtl/uart_fmt_reg.sv
module uart_fmt_reg
    import uart_tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      we,
    input  line_fmt_t wdata,
    output line_fmt_t fmt_q
);

    always_ff @(posedge clk) begin
        if (rst)
            fmt_q <= '0;
        else if (we)
            fmt_q <= wdata;
    end

endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         pull,
    output logic         full,
    output logic [W-1:0] word
);

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            word <= '0;
        end else if (load && !full) begin
            full <= 1'b1;
            word <= din;
        end else if (pull) begin
            full <= 1'b0;
        end
    end

endmodule

// File: rtl/uart_bit_timer.sv
module uart_bit_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic             clear,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);

    logic [CNT_W-1:0] cnt;

    assign done = run && tick && (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt <= '0;
        else if (run && tick)
            cnt <= done ? '0 : cnt + 1'b1;
    end

endmodule

// File: rtl/uart_tx_seq.sv
module uart_tx_seq
    import uart_tx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        hold_full,
    input  frame_plan_t next_plan,
    output logic        pull,
    output logic        active,
    output logic        txd
);

    localparam int CNT_W = $clog2(2 * OVERSAMPLE);
    localparam logic [CNT_W-1:0] LIM_ONE      = CNT_W'(OVERSAMPLE - 1);
    localparam logic [CNT_W-1:0] LIM_ONE_HALF = CNT_W'(OVERSAMPLE + OVERSAMPLE / 2 - 1);
    localparam logic [CNT_W-1:0] LIM_TWO      = CNT_W'(2 * OVERSAMPLE - 1);

    tx_phase_e        phase;
    frame_plan_t      plan_q;
    logic [IDX_W-1:0] bit_idx;
    logic [CNT_W-1:0] limit;
    logic             done;
    logic             from_idle;

    assign active    = (phase != TX_IDLE);
    assign from_idle = (phase == TX_IDLE) && hold_full;
    assign pull      = from_idle || (hold_full && (phase == TX_STOP) && done);

    always_comb begin
        limit = LIM_ONE;
        if (phase == TX_STOP) begin
            case (plan_q.stop_len)
                STOP_1P5: limit = LIM_ONE_HALF;
                STOP_2:   limit = LIM_TWO;
                default:  limit = LIM_ONE;
            endcase
        end
    end

    uart_bit_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (active),
        .tick (tick),
        .clear(from_idle),
        .limit(limit),
        .done (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= TX_IDLE;
            plan_q  <= '0;
            bit_idx <= '0;
        end else if (pull) begin
            phase   <= TX_START;
            plan_q  <= next_plan;
            bit_idx <= '0;
        end else if (done) begin
            case (phase)
                TX_START: phase <= TX_DATA;
                TX_DATA: begin
                    if (bit_idx == plan_q.last_idx) begin
                        phase <= plan_q.par_on ? TX_PARITY : TX_STOP;
                    end else begin
                        bit_idx     <= bit_idx + 1'b1;
                        plan_q.bits <= plan_q.bits >> 1;
                    end
                end
                TX_PARITY: phase <= TX_STOP;
                TX_STOP:   phase <= TX_IDLE;
                default:   phase <= TX_IDLE;
            endcase
        end
    end

    always_comb begin
        case (phase)
            TX_START:  txd = 1'b0;
            TX_DATA:   txd = plan_q.bits[0];
            TX_PARITY: txd = plan_q.par_val;
            default:   txd = 1'b1;
        endcase
    end

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uart_tx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic [WORD_MAX-1:0] tx_data,
    input  logic                tx_load,
    input  logic                cfg_we,
    input  logic [7:0]          cfg_wdata,
    output logic [7:0]          cfg_rdata,
    output logic                txd,
    output logic                busy,
    output logic                empty
);

    line_fmt_t           fmt_q;
    logic                hold_full;
    logic [WORD_MAX-1:0] hold_word;
    logic                pull;
    logic                seq_active;
    frame_plan_t         next_plan;

    uart_fmt_reg u_fmt (
        .clk  (clk),
        .rst  (rst),
        .we   (cfg_we),
        .wdata(line_fmt_t'(cfg_wdata)),
        .fmt_q(fmt_q)
    );

    uart_tx_hold #(
        .W(WORD_MAX)
    ) u_hold (
        .clk (clk),
        .rst (rst),
        .load(tx_load),
        .din (tx_data),
        .pull(pull),
        .full(hold_full),
        .word(hold_word)
    );

    assign next_plan = plan_frame(hold_word, fmt_q);

    uart_tx_seq #(
        .OVERSAMPLE(OVERSAMPLE)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .hold_full(hold_full),
        .next_plan(next_plan),
        .pull     (pull),
        .active   (seq_active),
        .txd      (txd)
    );

    assign cfg_rdata = fmt_q;
    assign busy      = hold_full;
    assign empty     = !hold_full && !seq_active;

endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic       tx_load,
    input logic       cfg_we,
    input logic [7:0] cfg_wdata,
    input logic [7:0] cfg_rdata,
    input logic       txd,
    input logic       busy,
    input logic       empty,
    input logic       seq_active
);

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
        empty |-> txd); // R9

    AST_EMPTY_MEANS_QUIET: assert property (@(posedge clk) disable iff (rst)
        empty |-> !seq_active); // R9

    AST_LOAD_FILLS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (tx_load && !busy) |=> busy); // R8

    AST_BUSY_NEEDS_LOAD: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(tx_load)); // R8

    AST_CFG_READBACK: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cfg_we)) |-> (cfg_rdata == $past(cfg_wdata))); // R5

    AST_LINE_WAITS_FOR_TICK: assert property (@(posedge clk) disable iff (rst)
        (seq_active && !tick) |=> $stable(txd)); // R6

    AST_FRAME_OPENS_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(seq_active) |-> !txd); // R1

endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .tx_load   (tx_load),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .txd       (txd),
    .busy      (busy),
    .empty     (empty),
    .seq_active(seq_active)
);

// File: tb/sim_uart_frame_tx.sv
`timescale 1ns/1ps
module sim_uart_frame_tx;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_load = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       txd, busy, empty;

    typedef struct {
        logic [7:0] d;
        logic [7:0] f;
    } exp_t;

    exp_t       q[$];
    int         n_checks = 0;
    int         n_fail = 0;
    int         frames_pushed = 0;
    int         frames_seen = 0;
    logic [7:0] cur_fmt = '0;

    uart_frame_tx #(.OVERSAMPLE(16)) u0 (
        .clk(clk), .rst(rst), .tick(tick),
        .tx_data(tx_data), .tx_load(tx_load),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .txd(txd), .busy(busy), .empty(empty)
    );

    always #4 clk = ~clk;

    // tick every fourth clock, changed just after the rising edge
    initial begin
        int tc = 0;
        forever begin
            @(posedge clk);
            #1;
            tc++;
            tick = !rst && (tc % 4 == 0);
        end
    end

    task automatic chk(bit ok, string what, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, expv);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    task automatic next_tick();
        do @(negedge clk); while (tick !== 1'b1);
    endtask

    // Monitor: sample the line once per tick and compare with the queue
    initial begin
        bit have_start = 0;
        forever begin
            exp_t e;
            logic lv[$];
            int   nb, errs, st, exp_st;
            logic [7:0] m;
            if (!have_start) begin
                do next_tick(); while (txd !== 1'b0);
            end
            have_start = 0;
            if (q.size() == 0) begin
                chk(0, "R8 frame seen with nothing queued", 1, 0);
                do next_tick(); while (txd !== 1'b1);
                continue;
            end
            e = q.pop_front();
            frames_seen++;
            nb = 5 + int'(e.f[1:0]);
            m = 8'h00;
            lv.delete();
            lv.push_back(1'b0);
            for (int i = 0; i < nb; i++) begin
                lv.push_back(e.d[i]);
                m[i] = e.d[i];
            end
            if (e.f[3]) lv.push_back(e.f[4] ? (^m) : ~(^m));
            exp_st = !e.f[2] ? 16 : ((e.f[1:0] == 2'b00) ? 24 : 32);
            errs = 0;
            for (int j = 0; j < lv.size(); j++) begin
                for (int k = 0; k < 16; k++) begin
                    if (j != 0 || k != 0) next_tick();
                    if (txd !== lv[j]) errs++;
                end
            end
            chk(errs == 0, $sformatf("R1 R4 R6 R7 frame bits data=%0h fmt=%0h mismatching samples",
                                     e.d, e.f), errs, 0);
            st = 0;
            forever begin
                next_tick();
                if (txd === 1'b1 && empty === 1'b0) st++;
                else break;
            end
            if (txd === 1'b0) have_start = 1;
            chk(st == exp_st, $sformatf("R2 R3 R10 stop ticks fmt=%0h", e.f), st, exp_st);
        end
    end

    task automatic cfg_write(logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        cur_fmt = v;
        @(negedge clk);
        cfg_we = 1'b0;
        chk(cfg_rdata === v, "R5 format readback", cfg_rdata, v);
    endtask

    task automatic send(logic [7:0] d);
        do @(negedge clk); while (busy !== 1'b0);
        tx_data = d;
        tx_load = 1'b1;
        q.push_back('{d: d, f: cur_fmt});
        frames_pushed++;
        @(negedge clk);
        tx_load = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!(empty === 1'b1 && q.size() == 0));
        repeat (40) @(negedge clk);
        chk(empty === 1'b1, "R9 empty after last stop", empty, 1);
        chk(txd === 1'b1, "R9 idle line high", txd, 1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(txd === 1'b1, "R9 reset txd", txd, 1);
        chk(busy === 1'b0, "R9 reset busy", busy, 0);
        chk(empty === 1'b1, "R9 reset empty", empty, 1);
        chk(cfg_rdata === 8'h00, "R5 reset format", cfg_rdata, 0);

        cfg_write(8'hA5);
        cfg_write(8'h03); send(8'h5A); wait_idle();   // R1 8 bits, R2
        cfg_write(8'h00); send(8'hFF); wait_idle();   // R1 upper bits dropped
        cfg_write(8'h04); send(8'h13); wait_idle();   // R3 one and a half
        cfg_write(8'h06); send(8'h2C); wait_idle();   // R3 two stop bits
        cfg_write(8'h1B); send(8'hB7); wait_idle();   // R4 even parity
        cfg_write(8'h0D); send(8'h3A); wait_idle();   // R4 odd parity, R3
        cfg_write(8'hE9); send(8'h66); wait_idle();   // R5 spare bits inert

        // R8 and R10: queue one byte behind another, then a load that must be dropped
        cfg_write(8'h03);
        send(8'h81);
        repeat (3) @(negedge clk);
        send(8'h7E);
        chk(busy === 1'b1, "R8 busy with byte held", busy, 1);
        chk(empty === 1'b0, "R9 not empty while sending", empty, 0);
        @(negedge clk);
        tx_data = 8'h55;
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
        wait_idle();
        chk(frames_seen == frames_pushed, "R8 load while busy ignored", frames_seen, frames_pushed);

        // R7: format change in the middle of a frame
        send(8'hC3);
        repeat (300) @(negedge clk);
        cfg_write(8'h00);
        wait_idle();
        send(8'h1F); wait_idle();

        // R7: format write in the very cycle the byte enters the serializer
        send(8'h96);
        cfg_we = 1'b1;
        cfg_wdata = 8'h1F;
        cur_fmt = 8'h1F;
        @(negedge clk);
        cfg_we = 1'b0;
        wait_idle();
        send(8'h4B); wait_idle();

        chk(frames_seen == frames_pushed, "R7 R8 frame count", frames_seen, frames_pushed);
        chk(q.size() == 0, "R8 nothing left queued", q.size(), 0);
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R9 watchdog expired actual=1 expected=0");
        summary();
        $finish;
    end

endmodule